// File: doc/BRIEF.md
# Multi-Voice Sine Tone Generator

This block produces sine-wave samples for several notes at once by direct digital synthesis. Every voice owns a phase register that moves forward by that voice's tuning increment each time a sample-rate tick arrives. The output frequency of a voice is the tick rate times its increment divided by the phase range.

Between two ticks a small sequencer visits the voices one after another. Each voice's phase is folded into the first quarter of a sine period, looked up in one shared table, and negated when it lies in the lower half-wave. The generator emits one signed amplitude per voice with a one-cycle strobe and the index of the voice it belongs to, so a mixer downstream can sum the voices into one sample. After the last voice the output rests at zero until the next tick.

Top module: `dds_tone_gen`

## Requirements
- R1: Each voice's 16-bit phase adds its 11-bit increment once per clock in which `tick_i` is high, wrapping modulo 65536. Without a tick the phases do not move. All phases are 0 after reset.
- R2: The increment of voice v is taken from bits [11v+10 : 11v] of `tune_words_i` in the cycle the tick is sampled.
- R3: Counting the clock edge that samples the tick as edge 0, the strobe for voice 0 is visible after edge 2. The cycle after edge 0 is a settling cycle with the output at 0.
- R4: Each voice is held for two cycles. The strobe pulses once per voice, after edges 2+2v, with `voice_o` = v, never on two cycles in a row, and only for v below the voice count.
- R5: Once every voice has been issued, `voice_o` equals the voice count, `amp_o` is 0, and no strobe occurs until the next tick.
- R6: The quarter table has 2^8 entries. Entry i holds round(32767 * sin(pi/2 * (i+0.5)/256)). In quadrant 0 (phase bits 15:14 = 00) the output is entry phase[13:6].
- R7: In quadrant 1 (bits 15:14 = 01) the output is entry 255 - phase[13:6], the mirrored index.
- R8: In quadrants 2 and 3 the output is the two's-complement negation (invert all bits, add one) of the quadrant-0 and quadrant-1 results respectively, on a 16-bit vector.
- R9: During reset `amp_o` is 0, `amp_vld_o` is 0 and `voice_o` equals the voice count.
- R10: A tick that arrives while voices are still being issued restarts the sequence. The timing of R3 and R4 holds from the new tick, using the newly advanced phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Sample-rate tick, one cycle high |
| tune_words_i | input | 44 | Packed per-voice phase increments, 11 bits each |
| amp_o | output | 16 | Two's-complement amplitude of the voice being issued |
| amp_vld_o | output | 1 | One-cycle strobe marking a fresh voice amplitude |
| voice_o | output | 3 | Voice index of `amp_o`; equals the voice count when idle |

## Verification
The assertions check on every cycle that the strobe never lasts two cycles, that it only ever carries a real voice index, that the idle index always brings a zero output, that the phases stay frozen between ticks, and that voice 0 appears exactly two edges after an isolated tick. The table values, the quadrant folding and negation, the per-voice field slicing and the wrap of the phases can only be shown by the bench. It keeps its own phase totals and a floating-point sine, and compares amplitude, strobe and index on every clock across fixed, random and back-to-back tick patterns.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;

  typedef enum logic [1:0] {
    QUAD_RISE  = 2'b00,
    QUAD_FALL  = 2'b01,
    QUAD_NRISE = 2'b10,
    QUAD_NFALL = 2'b11
  } quad_e;

  // Quarter-wave sample i of a table with 'depth' entries, scaled to the
  // largest positive value of an amp_w-bit two's-complement word.
  function automatic int qsine_entry(input int idx, input int depth, input int amp_w);
    real x;
    real term;
    real acc;
    real amax;
    x    = 1.5707963267948966 * (real'(idx) + 0.5) / real'(depth);
    term = x;
    acc  = x;
    for (int n = 1; n <= 12; n++) begin
      term = -term * x * x / real'((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    amax = real'((1 << (amp_w - 1)) - 1);
    return $rtoi(acc * amax + 0.5);
  endfunction

endpackage

// File: rtl/dds_phase_bank.sv
`timescale 1ns/1ps
module dds_phase_bank #(
  parameter int N_NOTES = 4,
  parameter int PHASE_W = 16,
  parameter int TW_W    = 11,
  parameter int OUT_W   = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       step_en,
  input  logic [N_NOTES*TW_W-1:0]    tune_words,
  output logic [N_NOTES*OUT_W-1:0]   phases
);

  for (genvar v = 0; v < N_NOTES; v++) begin : g_acc
    logic [PHASE_W-1:0] acc_q;
    logic [PHASE_W-1:0] acc_d;

    always_comb begin
      acc_d = acc_q;
      if (step_en) begin
        acc_d = acc_q + PHASE_W'(tune_words[v*TW_W +: TW_W]);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q <= '0;
      end else begin
        acc_q <= acc_d;
      end
    end

    assign phases[v*OUT_W +: OUT_W] = acc_q[PHASE_W-1 -: OUT_W];
  end

endmodule

// File: rtl/dds_voice_seq.sv
`timescale 1ns/1ps
module dds_voice_seq #(
  parameter int N_NOTES = 4,
  parameter int VOICE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  output logic [VOICE_W-1:0] sel_o,
  output logic               active_o,
  output logic               issue_o
);

  localparam logic [VOICE_W-1:0] IDLE_SEL = VOICE_W'(N_NOTES);

  logic               arm_q, arm_d;
  logic               half_q, half_d;
  logic [VOICE_W-1:0] sel_q, sel_d;

  always_comb begin
    arm_d  = 1'b0;
    half_d = half_q;
    sel_d  = sel_q;
    if (tick) begin
      arm_d  = 1'b1;
      half_d = 1'b0;
      sel_d  = IDLE_SEL;
    end else if (arm_q) begin
      half_d = 1'b0;
      sel_d  = '0;
    end else if (sel_q != IDLE_SEL) begin
      if (half_q) begin
        half_d = 1'b0;
        sel_d  = sel_q + VOICE_W'(1);
      end else begin
        half_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      half_q <= 1'b0;
      sel_q  <= IDLE_SEL;
    end else begin
      arm_q  <= arm_d;
      half_q <= half_d;
      sel_q  <= sel_d;
    end
  end

  assign sel_o    = sel_q;
  assign active_o = (sel_q != IDLE_SEL);
  assign issue_o  = (sel_q != IDLE_SEL) && !half_q;

endmodule

// File: rtl/dds_quarter_lut.sv
`timescale 1ns/1ps
module dds_quarter_lut #(
  parameter int LUT_AW  = 8,
  parameter int AMP_W   = 16,
  parameter int VOICE_W = 3,
  parameter int N_NOTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active_i,
  input  logic               issue_i,
  input  logic [VOICE_W-1:0] voice_i,
  input  logic [LUT_AW+1:0]  phase_i,
  output logic [AMP_W-1:0]   amp_o,
  output logic               vld_o,
  output logic [VOICE_W-1:0] voice_o
);
  import dds_pkg::*;

  localparam int DEPTH = 1 << LUT_AW;

  logic [AMP_W-1:0] rom_w [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_rom
    assign rom_w[k] = AMP_W'(qsine_entry(k, DEPTH, AMP_W));
  end

  quad_e             quad;
  logic [LUT_AW-1:0] idx;
  logic              negate;

  always_comb begin
    quad   = quad_e'(phase_i[LUT_AW+1 -: 2]);
    idx    = phase_i[LUT_AW-1:0];
    negate = 1'b0;
    case (quad)
      QUAD_RISE:  begin idx = phase_i[LUT_AW-1:0];  negate = 1'b0; end
      QUAD_FALL:  begin idx = ~phase_i[LUT_AW-1:0]; negate = 1'b0; end
      QUAD_NRISE: begin idx = phase_i[LUT_AW-1:0];  negate = 1'b1; end
      QUAD_NFALL: begin idx = ~phase_i[LUT_AW-1:0]; negate = 1'b1; end
      default:    begin idx = phase_i[LUT_AW-1:0];  negate = 1'b0; end
    endcase
  end

  logic [AMP_W-1:0]   mag_q, mag_d;
  logic               neg_q, neg_d;
  logic               vld_q;
  logic [VOICE_W-1:0] voice_q;

  always_comb begin
    mag_d = '0;
    neg_d = 1'b0;
    if (active_i) begin
      mag_d = rom_w[idx];
      neg_d = negate;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q   <= '0;
      neg_q   <= 1'b0;
      vld_q   <= 1'b0;
      voice_q <= VOICE_W'(N_NOTES);
    end else begin
      mag_q   <= mag_d;
      neg_q   <= neg_d;
      vld_q   <= issue_i;
      voice_q <= voice_i;
    end
  end

  assign amp_o   = neg_q ? (~mag_q + AMP_W'(1)) : mag_q;
  assign vld_o   = vld_q;
  assign voice_o = voice_q;

endmodule

// File: rtl/dds_tone_gen.sv
`timescale 1ns/1ps
module dds_tone_gen #(
  parameter int N_NOTES = 4,
  parameter int PHASE_W = 16,
  parameter int TW_W    = 11,
  parameter int AMP_W   = 16,
  parameter int LUT_AW  = 8,
  localparam int VOICE_W = $clog2(N_NOTES + 1),
  localparam int SLICE_W = LUT_AW + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_i,
  input  logic [N_NOTES*TW_W-1:0] tune_words_i,
  output logic [AMP_W-1:0]        amp_o,
  output logic                    amp_vld_o,
  output logic [VOICE_W-1:0]      voice_o
);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [N_NOTES*SLICE_W-1:0] phase_bus;
  logic [VOICE_W-1:0]         sel;
  logic                       active;
  logic                       issue;
  logic [SLICE_W-1:0]         sel_phase;

  dds_phase_bank #(
    .N_NOTES (N_NOTES),
    .PHASE_W (PHASE_W),
    .TW_W    (TW_W),
    .OUT_W   (SLICE_W)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .step_en    (tick_i),
    .tune_words (tune_words_i),
    .phases     (phase_bus)
  );

  dds_voice_seq #(
    .N_NOTES (N_NOTES),
    .VOICE_W (VOICE_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (tick_i),
    .sel_o    (sel),
    .active_o (active),
    .issue_o  (issue)
  );

  always_comb begin
    sel_phase = '0;
    for (int v = 0; v < N_NOTES; v++) begin
      if (sel == VOICE_W'(v)) begin
        sel_phase = phase_bus[v*SLICE_W +: SLICE_W];
      end
    end
  end

  dds_quarter_lut #(
    .LUT_AW  (LUT_AW),
    .AMP_W   (AMP_W),
    .VOICE_W (VOICE_W),
    .N_NOTES (N_NOTES)
  ) u_lut (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .active_i (active),
    .issue_i  (issue),
    .voice_i  (sel),
    .phase_i  (sel_phase),
    .amp_o    (amp_o),
    .vld_o    (amp_vld_o),
    .voice_o  (voice_o)
  );

endmodule

// File: rtl/dds_tone_gen_chk.sv
`timescale 1ns/1ps
module dds_tone_gen_chk #(
  parameter int N_NOTES = 4,
  parameter int AMP_W   = 16,
  parameter int VOICE_W = 3,
  parameter int BUS_W   = 40
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               tick_i,
  input logic [AMP_W-1:0]   amp_o,
  input logic               amp_vld_o,
  input logic [VOICE_W-1:0] voice_o,
  input logic [BUS_W-1:0]   phase_bus
);

  p_phase_hold_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tick_i |=> $stable(phase_bus))
    else $error("phases moved without a tick");

  p_first_voice_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick_i ##1 !tick_i) |=> ##1 (amp_vld_o && voice_o == '0))
    else $error("voice 0 strobe not two edges after tick");

  p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    amp_vld_o |=> !amp_vld_o)
    else $error("strobe held for two cycles");

  p_strobe_voice_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    amp_vld_o |-> (voice_o < VOICE_W'(N_NOTES)))
    else $error("strobe with idle voice index");

  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (voice_o == VOICE_W'(N_NOTES)) |-> (amp_o == '0 && !amp_vld_o))
    else $error("idle output not zero");

endmodule

bind dds_tone_gen dds_tone_gen_chk #(
  .N_NOTES (N_NOTES),
  .AMP_W   (AMP_W),
  .VOICE_W (VOICE_W),
  .BUS_W   (N_NOTES*SLICE_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .tick_i     (tick_i),
  .amp_o      (amp_o),
  .amp_vld_o  (amp_vld_o),
  .voice_o    (voice_o),
  .phase_bus  (phase_bus)
);

// File: tb/tb_dds_tone_gen.sv
`timescale 1ns/1ps
module tb_dds_tone_gen;
  localparam int N       = 4;
  localparam int TW      = 11;
  localparam int AW      = 16;
  localparam int VW      = 3;
  localparam int SEQ_END = 2 + 2 * N;
  localparam int IDLE_K  = 1000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            tick = 1'b0;
  logic [N*TW-1:0] tw = '0;
  logic [AW-1:0]   amp;
  logic            vld;
  logic [VW-1:0]   voice;

  always #5 clk = ~clk;

  dds_tone_gen dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick),
    .tune_words_i (tw),
    .amp_o        (amp),
    .amp_vld_o    (vld),
    .voice_o      (voice)
  );

  int nchk  = 0;
  int nfail = 0;
  int mph[N];
  int k = IDLE_K;
  bit restarted = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Expected sample from the requirements: quadrant fold, then sine, then sign.
  function automatic int exp_amp(input int ph);
    int q, idx, v;
    q   = (ph >> 14) & 3;
    idx = (ph >> 6) & 255;
    if (q % 2 == 1) idx = 255 - idx;
    v = $rtoi(32767.0 * $sin(1.5707963267948966 * (real'(idx) + 0.5) / 256.0) + 0.5);
    if (q >= 2) v = -v;
    return v & 16'hffff;
  endfunction

  // Reference model: phase totals (R1, R2) and cycles since the last tick.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int v = 0; v < N; v++) mph[v] = 0;
      k = IDLE_K;
      restarted = 1'b0;
    end else if (tick) begin
      restarted = (k < SEQ_END);
      for (int v = 0; v < N; v++) mph[v] = (mph[v] + int'(tw[v*TW +: TW])) % 65536;
      k = 0;
    end else if (k < IDLE_K) begin
      k = k + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done && !(k == 0 && restarted)) begin
      bit    exp_v;
      int    ea;
      int    vi;
      string tag;
      exp_v = (k >= 2) && (k < SEQ_END) && (k % 2 == 0);
      chk(vld == exp_v, restarted ? "R10 strobe" : "R3 R4 strobe", int'(vld), int'(exp_v));
      if (k >= 2 && k < SEQ_END) begin
        vi = (k - 2) / 2;
        ea = exp_amp(mph[vi]);
        case ((mph[vi] >> 14) & 3)
          0:       tag = "R6 R1 R2 amp";
          1:       tag = "R7 amp";
          default: tag = "R8 amp";
        endcase
        if (exp_v) chk(int'(voice) == vi, vi == 0 ? "R3 voice" : "R4 voice", int'(voice), vi);
      end else begin
        ea  = 0;
        tag = "R5 idle amp";
        if (k >= SEQ_END) chk(int'(voice) == N, "R5 idle voice", int'(voice), N);
      end
      chk(int'(amp) == ea, tag, int'(amp), ea);
    end
  end

  task automatic do_tick(input int gap);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    // R9: reset state
    repeat (3) begin
      @(negedge clk);
      chk(amp == '0, "R9 amp", int'(amp), 0);
      chk(vld == 1'b0, "R9 strobe", int'(vld), 0);
      chk(int'(voice) == N, "R9 voice", int'(voice), N);
    end
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R2: distinct fixed increments per field, including max and zero
    tw = {11'd0, 11'd600, 11'd1, 11'd2047};
    repeat (40) do_tick(12);

    // R1: a long pause without ticks must leave the phases unchanged
    repeat (60) @(negedge clk);
    repeat (5) do_tick(12);

    // Random increments and gaps across all quadrants (R6, R7, R8)
    for (int i = 0; i < 300; i++) begin
      for (int v = 0; v < N; v++) tw[v*TW +: TW] = TW'($urandom);
      do_tick(11 + int'($urandom % 6));
      if (i % 50 == 0) repeat (40) @(negedge clk);
    end

    // R10: ticks arriving before the sequence has finished
    for (int i = 0; i < 30; i++) begin
      for (int v = 0; v < N; v++) tw[v*TW +: TW] = TW'($urandom);
      do_tick(4 + int'($urandom % 4));
    end
    repeat (3) do_tick(12);
    repeat (20) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule